// File: doc/BRIEF.md
# Background Tile Fetch Sequencer

This block produces the background pattern stream of a tile-based video controller, one pixel per dot. The dot counter and the scanline counter come from outside. From them the block runs a fixed eight-dot memory schedule on every visible line. The four reads in each group are:

- the tile index from the name table,
- the attribute byte that covers the tile,
- the low bit-plane of the tile row,
- the high bit-plane of the tile row.

At the end of each group the fetched bytes become the current tile. During the next group, each dot outputs a 2-bit pattern value selected by the dot's position within the tile. The attribute byte of that tile is output alongside the pixel.

The memory port is synchronous. An address presented with the read strobe in one cycle returns its data in the next cycle. Each read is therefore issued on an even phase of the group, and its data is captured on the odd phase that follows. A separate strobe marks the dot window in which the sprite memory address register has to be cleared. Palette lookup, scrolling and sprites belong to other blocks.

Top module: `bg_fetch_seq`

## Requirements
- R1: The fetch phase is (dot − 1) mod 8. Reads (`mem_rd` = 1) happen only on visible lines (scanline < 240), only on dots 1 to 248, and only on even phases 0, 2, 4 and 6. There is no read on dot 0, on dots 249 to 340, or on any other line.
- R2: On phase 0 the address is 0x2000 + (scanline / 8) × 32 + column, where column = (dot − 1) / 8.
- R3: On phase 2 the address is 0x23C0 + (scanline / 32) × 8 + column / 4.
- R4: On phase 4 the address is bank × 0x1000 + tile × 16 + (scanline mod 8). The tile is the byte returned by the phase-0 read of the same group. The bank is the `pat_bank` input.
- R5: On phase 6 the address is the phase-4 address plus 8.
- R6: The data captured on phase 7 commits all fetched bytes as the current tile. Tile column c is output on dots 8c + 9 to 8c + 16. Each pixel and its attribute appear at the outputs one clock after the dot is presented.
- R7: For fine_x = (dot − 1) mod 8, bit 0 of `pix_val` is bit (7 − fine_x) of the low plane and bit 1 is the same bit of the high plane. The leftmost pixel therefore uses the most significant bit.
- R8: `pix_valid` is 1 only for dots 1 to 256 of a visible line with `show_bg` = 1. Whenever `pix_valid` is 0, `pix_val` is 0.
- R9: `oam_clr` is 1 on dots 257 to 320 of visible lines and of the pre-render line 261, and 0 on every other dot and line.
- R10: `attr_out` gives the attribute byte of the tile being drawn, aligned with `pix_val`.
- R11: After reset `pix_valid`, `pix_val` and `attr_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scanline | input | 9 | Current line number |
| dot | input | 9 | Current dot within the line |
| show_bg | input | 1 | Background display enable |
| pat_bank | input | 1 | Pattern table bank select |
| mem_rd | output | 1 | Read strobe to video memory |
| mem_addr | output | 14 | Read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the strobe |
| pix_valid | output | 1 | Pixel output valid |
| pix_val | output | 2 | Pattern value of the pixel |
| attr_out | output | 8 | Attribute byte of the tile being drawn |
| oam_clr | output | 1 | Strobe that clears the sprite address register |

## Verification
`mem_rd`, `mem_addr` and `oam_clr` are combinational on the dot and scanline presented. The bench checks them 1 ns after it drives a new dot, before the next clock edge. `pix_valid`, `pix_val` and `attr_out` belong to the dot presented one clock earlier. The bench therefore checks them at the next falling edge against the dot it drove before, with the tile column for dot d taken as (d − 1) / 8 − 1. Expected bytes come from a bench hash of the address. That hash also backs a one-cycle-latency memory model, so every pattern address and every pixel can be recomputed without reading any internal state.

// File: rtl/bg_fetch_pkg.sv
// Shared definitions for the background fetch sequencer.
// Assumes a 14-bit video address space and 9-bit line and dot counters.
package bg_fetch_pkg;
    localparam int ADDR_W = 14;
    localparam int CNT_W  = 9;

    typedef enum logic [1:0] {
        SLOT_NAME = 2'd0,
        SLOT_ATTR = 2'd1,
        SLOT_PLO  = 2'd2,
        SLOT_PHI  = 2'd3
    } fetch_slot_e;

    // Maps a fetch phase (0..7) onto the read slot that owns it.
    function automatic fetch_slot_e slot_of(input logic [2:0] phase);
        return fetch_slot_e'(phase[2:1]);
    endfunction
endpackage

// File: rtl/bg_fetch_addr.sv
// Phase decoder and read-address former.
// Works out the fetch phase from the dot counter and gates the fetch and draw windows.
// Drives a combinational read address on the even phases.
// Assumes the tile index captured on phase 1 is stable by phase 4.
module bg_fetch_addr
    import bg_fetch_pkg::*;
#(
    parameter int VIS_LINES  = 240,
    parameter int FETCH_LAST = 248,
    parameter int DRAW_LAST  = 256,
    parameter logic [ADDR_W-1:0] NAME_BASE = 14'h2000,
    parameter logic [ADDR_W-1:0] ATTR_BASE = 14'h23C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  scanline,
    input  logic [CNT_W-1:0]  dot,
    input  logic              pat_bank,
    input  logic [7:0]        tile_idx,
    output logic [2:0]        phase,
    output logic              fetch_en,
    output logic              draw_en,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int PLANE_OFS = 8;

    logic [CNT_W-1:0] dot_m1;
    logic [4:0]       tile_col;
    logic [4:0]       tile_row;
    logic [2:0]       fine_y;
    logic             vis_line;
    logic [ADDR_W-1:0] plane_base;

    // Phase, tile coordinates and window decode.
    always_comb begin
        dot_m1   = dot - CNT_W'(1);
        phase    = dot_m1[2:0];
        tile_col = dot_m1[7:3];
        tile_row = scanline[7:3];
        fine_y   = scanline[2:0];
        vis_line = (scanline < CNT_W'(VIS_LINES));
        fetch_en = vis_line && (dot != '0) && (dot_m1 < CNT_W'(FETCH_LAST));
        draw_en  = vis_line && (dot != '0) && (dot_m1 < CNT_W'(DRAW_LAST));
        mem_rd   = fetch_en && !phase[0];
    end

    // Address of the read issued in the current slot.
    always_comb begin
        plane_base = ADDR_W'({pat_bank, tile_idx, 4'b0000}) + ADDR_W'(fine_y);
        unique case (slot_of(phase))
            SLOT_NAME: mem_addr = NAME_BASE + ADDR_W'({tile_row, tile_col});
            SLOT_ATTR: mem_addr = ATTR_BASE + ADDR_W'({tile_row[4:2], tile_col[4:2]});
            SLOT_PLO:  mem_addr = plane_base;
            SLOT_PHI:  mem_addr = plane_base + ADDR_W'(PLANE_OFS);
            default:   mem_addr = '0;
        endcase
    end

    // R1
    rd_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (draw_en && fetch_en));
endmodule

// File: rtl/bg_tile_regs.sv
// Next-tile capture registers and the current-tile commit.
// Captures read data on the odd phases. Commits on phase 7, when the high plane arrives.
// Assumes the read data is valid exactly one cycle after its strobe.
module bg_tile_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch_en,
    input  logic [2:0] phase,
    input  logic [7:0] mem_rdata,
    output logic [7:0] tile_idx,
    output logic [7:0] cur_lo,
    output logic [7:0] cur_hi,
    output logic [7:0] cur_attr
);
    logic [7:0] nxt_attr;
    logic [7:0] nxt_lo;

    // Capture each returned byte into its next-tile register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tile_idx <= '0;
            nxt_attr <= '0;
            nxt_lo   <= '0;
        end else if (fetch_en) begin
            case (phase)
                3'd1: tile_idx <= mem_rdata;
                3'd3: nxt_attr <= mem_rdata;
                3'd5: nxt_lo   <= mem_rdata;
                default: ;
            endcase
        end
    end

    // Commit the finished tile at the end of the group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lo   <= '0;
            cur_hi   <= '0;
            cur_attr <= '0;
        end else if (fetch_en && phase == 3'd7) begin
            cur_lo   <= nxt_lo;
            cur_hi   <= mem_rdata;
            cur_attr <= nxt_attr;
        end
    end

    // R6
    commit_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && phase == 3'd7) |=> (cur_hi == $past(mem_rdata)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_en || phase != 3'd7) |=> $stable(cur_lo));
endmodule

// File: rtl/bg_pix_sel.sv
// Pixel selector and output register.
// Picks one bit per plane with the MSB as the leftmost pixel. Registers the result with its attribute byte.
// Forces the pixel to 0 whenever the output is not valid.
module bg_pix_sel #(
    parameter int PLANES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              draw_en,
    input  logic              show_bg,
    input  logic [2:0]        fine_x,
    input  logic [7:0]        cur_lo,
    input  logic [7:0]        cur_hi,
    input  logic [7:0]        cur_attr,
    output logic              pix_valid,
    output logic [PLANES-1:0] pix_val,
    output logic [7:0]        attr_out
);
    logic [7:0]        plane [PLANES];
    logic [PLANES-1:0] pick;

    assign plane[0] = cur_lo;
    assign plane[1] = cur_hi;

    // Select the bit of each plane for this fine X.
    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        assign pick[p] = plane[p][3'd7 - fine_x];
    end

    // Register the pixel, its valid flag and its attribute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_val   <= '0;
            attr_out  <= '0;
        end else begin
            pix_valid <= draw_en && show_bg;
            pix_val   <= (draw_en && show_bg) ? pick : '0;
            attr_out  <= cur_attr;
        end
    end

    // R8
    blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> (pix_val == '0));

    // R8
    show_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !show_bg |=> !pix_valid);
endmodule

// File: rtl/bg_fetch_seq.sv
// Background tile fetch sequencer, top level.
// Ties the address former, the tile registers and the pixel selector together.
// Decodes the sprite address clear window.
// Assumes the counters advance by one dot per clock.
module bg_fetch_seq
    import bg_fetch_pkg::*;
#(
    parameter int VIS_LINES  = 240,
    parameter int PRE_LINE   = 261,
    parameter int FETCH_LAST = 248,
    parameter int DRAW_LAST  = 256,
    parameter int CLR_FIRST  = 257,
    parameter int CLR_LAST   = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  scanline,
    input  logic [CNT_W-1:0]  dot,
    input  logic              show_bg,
    input  logic              pat_bank,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              pix_valid,
    output logic [1:0]        pix_val,
    output logic [7:0]        attr_out,
    output logic              oam_clr
);
    logic [2:0] phase;
    logic       fetch_en;
    logic       draw_en;
    logic [7:0] tile_idx;
    logic [7:0] cur_lo;
    logic [7:0] cur_hi;
    logic [7:0] cur_attr;

    bg_fetch_addr #(
        .VIS_LINES (VIS_LINES),
        .FETCH_LAST(FETCH_LAST),
        .DRAW_LAST (DRAW_LAST)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .scanline (scanline),
        .dot      (dot),
        .pat_bank (pat_bank),
        .tile_idx (tile_idx),
        .phase    (phase),
        .fetch_en (fetch_en),
        .draw_en  (draw_en),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr)
    );

    bg_tile_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch_en (fetch_en),
        .phase    (phase),
        .mem_rdata(mem_rdata),
        .tile_idx (tile_idx),
        .cur_lo   (cur_lo),
        .cur_hi   (cur_hi),
        .cur_attr (cur_attr)
    );

    bg_pix_sel #(.PLANES(2)) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .draw_en  (draw_en),
        .show_bg  (show_bg),
        .fine_x   (phase),
        .cur_lo   (cur_lo),
        .cur_hi   (cur_hi),
        .cur_attr (cur_attr),
        .pix_valid(pix_valid),
        .pix_val  (pix_val),
        .attr_out (attr_out)
    );

    // Sprite address clear window on visible and pre-render lines.
    always_comb begin
        oam_clr = ((scanline < CNT_W'(VIS_LINES)) || (scanline == CNT_W'(PRE_LINE)))
               && (dot >= CNT_W'(CLR_FIRST)) && (dot <= CNT_W'(CLR_LAST));
    end

    // R9
    clr_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oam_clr |-> !mem_rd);

    // R9
    clr_no_draw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oam_clr |=> !pix_valid);
endmodule

// File: tb/tb_bg_fetch_seq.sv
module tb_bg_fetch_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  scanline = '0;
    logic [8:0]  dot = '0;
    logic        show_bg = 1'b0;
    logic        pat_bank = 1'b0;
    logic        mem_rd;
    logic [13:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        pix_valid;
    logic [1:0]  pix_val;
    logic [7:0]  attr_out;
    logic        oam_clr;

    int checks = 0;
    int errors = 0;
    int pd = 0, psl = 300, pshow = 0, pbank = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bg_fetch_seq dut (
        .clk(clk), .rst_n(rst_n), .scanline(scanline), .dot(dot),
        .show_bg(show_bg), .pat_bank(pat_bank), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pix_valid(pix_valid),
        .pix_val(pix_val), .attr_out(attr_out), .oam_clr(oam_clr)
    );

    function automatic int memf(int a);
        int h = a * 151 + (a >> 5) * 29 + 90;
        return (h ^ (a >> 7)) & 8'hFF;
    endfunction

    // memory model with one cycle of read latency
    always @(posedge clk) if (mem_rd) mem_rdata <= 8'(memf(int'(mem_addr)));

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int plane_addr(int sl, int col, int bank);
        int nt = memf(32'h2000 + (sl / 8) * 32 + col);
        return bank * 4096 + nt * 16 + sl % 8;
    endfunction

    // outputs registered for the dot driven one clock earlier
    task automatic check_regs();
        int ev = (pshow != 0 && pd >= 1 && pd <= 256 && psl < 240) ? 1 : 0;
        chk("R8 valid", int'(pix_valid), ev);
        if (ev == 0) chk("R8 zero pixel", int'(pix_val), 0);
        else if (pd >= 9) begin
            int c = (pd - 1) / 8 - 1;
            int fx = (pd - 1) % 8;
            int base = plane_addr(psl, c, pbank);
            int lo = memf(base);
            int hi = memf(base + 8);
            int ep = (((hi >> (7 - fx)) & 1) << 1) | ((lo >> (7 - fx)) & 1);
            chk("R6/R7 pixel", int'(pix_val), ep);
            chk("R10 attr", int'(attr_out), memf(32'h23C0 + (psl / 32) * 8 + c / 4));
        end
    endtask

    // combinational outputs for the dot just driven
    task automatic check_comb(int sl, int d, int bank);
        int fetch = (sl < 240 && d >= 1 && d <= 248) ? 1 : 0;
        int ph = (d - 1) % 8;
        int col = (d - 1) / 8;
        int erd = (fetch != 0 && (ph % 2) == 0) ? 1 : 0;
        int eclr = ((sl < 240 || sl == 261) && d >= 257 && d <= 320) ? 1 : 0;
        chk("R1 read strobe", int'(mem_rd), erd);
        chk("R9 clear strobe", int'(oam_clr), eclr);
        if (erd != 0) begin
            case (ph)
                0: chk("R2 name addr", int'(mem_addr), 32'h2000 + (sl / 8) * 32 + col);
                2: chk("R3 attr addr", int'(mem_addr), 32'h23C0 + (sl / 32) * 8 + col / 4);
                4: chk("R4 low plane addr", int'(mem_addr), plane_addr(sl, col, bank));
                default: chk("R5 high plane addr", int'(mem_addr), plane_addr(sl, col, bank) + 8);
            endcase
        end
    endtask

    task automatic run_line(int sl, int show, int bank);
        for (int d = 0; d <= 340; d++) begin
            @(negedge clk);
            check_regs();
            scanline = 9'(sl);
            dot = 9'(d);
            show_bg = show[0];
            pat_bank = bank[0];
            #1;
            check_comb(sl, d, bank);
            pd = d; psl = sl; pshow = show; pbank = bank;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 valid", int'(pix_valid), 0);
        chk("R11 pixel", int'(pix_val), 0);
        chk("R11 attr", int'(attr_out), 0);
        // directed corners: first, last and blank lines, both banks, pre-render
        run_line(0, 1, 0);
        run_line(7, 1, 1);
        run_line(120, 0, 1);
        run_line(239, 1, 1);
        run_line(240, 1, 0);
        run_line(261, 1, 0);
        run_line(250, 1, 1);
        for (int i = 0; i < 10; i++) begin
            int sl = int'($urandom_range(0, 261));
            run_line(sl, int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));
        end
        @(negedge clk);
        check_regs();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule